// File: doc/BRIEF.md
# Display register-write command engine

This block runs a list of display register updates that software has prepared in memory ahead of time. Software fills a buffer with 64-bit instructions and sets a start address and an end address. It then arms the engine. The engine reads the buffer one qword at a time over a simple read port. It decodes each instruction and drives the resulting register writes on a valid/ready write port. It never issues register reads. While it works, a busy flag stays high. Software can stop it at any time by clearing the enable bit.

The instruction set covers the following:
- a no-op;
- a single register write;
- an indexed write, which sends a run of data words to one register offset;
- a wait for a number of microseconds, counted in clock cycles through a parameter;
- a wait for a number of rising edges on the vertical-blank input.

Every other opcode is skipped as one qword. Execution can also be held back until the next vertical-blank edge, so that a whole batch of updates lands inside the blanking interval.

Top module: `cmdq_engine`

## Requirements
- R1: After reset, `busy`, `mem_req` and `rw_valid` are all low.
- R2: The engine has three configuration registers, selected by `cfg_sel`: 0 is control (bit 0 enable, bit 1 start-on-vblank), 1 is the start address and 2 is the end address. A write to the end address starts the engine only if all three hold: control bit 0 is set, the engine is idle, and bits 5:0 of the written value are zero. Any other end-address write starts nothing.
- R3: Once started, the engine fetches qwords at the start address, then at +8, +16 and so on, in order. It keeps at most one request outstanding, and every request address is a multiple of 8. When the next fetch address equals the end address, the engine stops fetching and drops `busy`.
- R4: In an instruction qword, bits 63:56 hold the opcode, bits 55:52 the byte enables, and bits 51:32 the 20-bit register offset. Opcode 0x01 issues exactly one write, with data taken from bits 31:0.
- R5: Opcode 0x09 is an indexed write, and bits 31:0 give its word count N. The next N data words go to the header's offset, in address order: the low half of each following qword first, then its high half. When N is odd, the unused high half of the last qword is skipped. When N is 0, the instruction issues no write.
- R6: A byte-enable field of zero becomes 0xF on the write port, for both opcode 0x01 and opcode 0x09. `rw_be` is never zero while `rw_valid` is high.
- R7: Opcode 0x00, and every opcode other than 0x01, 0x02, 0x04 and 0x09, consumes one qword and issues no write.
- R8: Opcode 0x02 waits for N microseconds, where N is taken from bits 47:32 and one microsecond is `CYC_PER_US` cycles. With single-cycle memory and an always-ready write port, the write after the wait is accepted between N×`CYC_PER_US` and N×`CYC_PER_US`+16 cycles after the write before it.
- R9: Opcode 0x04 holds execution until N rising edges of `vblank` have been seen, with N taken from bits 47:32. When N is 0, there is no wait.
- R10: If control bit 1 is set at start, no fetch is made until the next rising edge of `vblank`.
- R11: A control write with bit 0 clear returns the engine to idle on the next cycle. After that, no further fetch or register write is issued.
- R12: While `rw_valid` is high and `rw_ready` is low, `rw_valid`, `rw_addr`, `rw_data` and `rw_be` hold their values until the write is accepted.
- R13: `busy` is high from the cycle after a start until the end address is reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 start address, 2 end address |
| cfg_wdata | input | 32 | Configuration write data |
| vblank | input | 1 | Vertical-blank level; its rising edges are counted |
| busy | output | 1 | Engine is executing |
| mem_req | output | 1 | Qword read request, one-cycle pulse |
| mem_addr | output | AW | Byte address of the requested qword |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read qword; bits 31:0 are the lower-addressed word |
| rw_valid | output | 1 | Register write request |
| rw_ready | input | 1 | Register write accepted |
| rw_addr | output | 20 | Register offset |
| rw_data | output | 32 | Register write data |
| rw_be | output | 4 | Byte enables |

## Verification
The hardest case to reach is an indexed write that is partway through its data while both sides stall. Its data words must stay in order across qword boundaries even when memory responses are late and the write port holds off. The odd-count pad word must be dropped rather than written. To get there, the bench sweeps indexed counts 0 through 5 in separate buffers. For the odd counts it turns on a slow memory and a write port that is ready only one cycle in four. After each indexed write it places a marker write, which proves that the engine took up the instruction stream again at the correct qword.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

    localparam logic [7:0] OP_NOP  = 8'h00;
    localparam logic [7:0] OP_WR   = 8'h01;
    localparam logic [7:0] OP_USEC = 8'h02;
    localparam logic [7:0] OP_VBL  = 8'h04;
    localparam logic [7:0] OP_IDX  = 8'h09;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_HEAD = 2'd1;
    localparam logic [1:0] SEL_TAIL = 2'd2;

    localparam int OFF_W   = 20;
    localparam int CNT_W   = 32;
    localparam int ALIGN_B = 6;

    typedef enum logic [1:0] {
        K_SKIP,
        K_WRITE,
        K_INDEXED,
        K_WAIT
    } kind_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_VSYNC,
        S_REQ,
        S_RESP,
        S_DEC,
        S_WR,
        S_DLO,
        S_DHI,
        S_WAIT
    } state_t;

endpackage

// File: rtl/cmdq_decode.sv
module cmdq_decode
    import cmdq_pkg::*;
#(
    parameter int WAIT_W = 16
) (
    input  logic [63:0]       qword,
    output kind_t             kind,
    output logic              wait_vbl,
    output logic [OFF_W-1:0]  offset,
    output logic [3:0]        be,
    output logic [CNT_W-1:0]  lo_word,
    output logic [WAIT_W-1:0] wait_cnt
);

    logic [7:0] opcode;
    logic [3:0] be_field;

    always_comb begin
        opcode   = qword[63:56];
        be_field = qword[55:52];
        offset   = qword[32 +: OFF_W];
        lo_word  = qword[31:0];
        wait_cnt = qword[32 +: WAIT_W];
        be       = (be_field == 4'h0) ? 4'hF : be_field;
        wait_vbl = 1'b0;
        case (opcode)
            OP_WR:   kind = K_WRITE;
            OP_IDX:  kind = K_INDEXED;
            OP_USEC: kind = K_WAIT;
            OP_VBL: begin
                kind     = K_WAIT;
                wait_vbl = 1'b1;
            end
            default: kind = K_SKIP;
        endcase
    end

endmodule

// File: rtl/cmdq_timer.sv
module cmdq_timer #(
    parameter int CYC_PER_US = 100,
    parameter int WAIT_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vblank,
    input  logic              clear,
    input  logic              load,
    input  logic              load_vbl,
    input  logic [WAIT_W-1:0] count,
    output logic              vbl_rise,
    output logic              active
);

    localparam int SUB_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
    localparam logic [SUB_W-1:0] SUB_TOP = SUB_W'(CYC_PER_US - 1);

    typedef struct packed {
        logic              vbl;
        logic              run;
        logic              on_vbl;
        logic [WAIT_W-1:0] units;
        logic [SUB_W-1:0]  sub;
    } tmr_t;

    tmr_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.vbl  = vblank;
        vbl_rise = vblank && !r_q.vbl;
        if (clear) begin
            r_d.run = 1'b0;
        end else if (load) begin
            r_d.run    = 1'b1;
            r_d.on_vbl = load_vbl;
            r_d.units  = count;
            r_d.sub    = SUB_TOP;
        end else if (r_q.run) begin
            if (r_q.on_vbl) begin
                if (vbl_rise) begin
                    if (r_q.units == WAIT_W'(1)) r_d.run = 1'b0;
                    else r_d.units = r_q.units - WAIT_W'(1);
                end
            end else if (r_q.sub == '0) begin
                if (r_q.units == WAIT_W'(1)) begin
                    r_d.run = 1'b0;
                end else begin
                    r_d.units = r_q.units - WAIT_W'(1);
                    r_d.sub   = SUB_TOP;
                end
            end else begin
                r_d.sub = r_q.sub - SUB_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign active = r_q.run;

endmodule

// File: rtl/cmdq_cfg.sv
module cmdq_cfg
    import cmdq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_sel,
    input  logic [31:0]   cfg_wdata,
    input  logic          idle,
    output logic          start,
    output logic          abort,
    output logic          vbl_first,
    output logic [AW-1:0] head,
    output logic [AW-1:0] tail
);

    typedef struct packed {
        logic          en;
        logic          vbl;
        logic [AW-1:0] head;
        logic [AW-1:0] tail;
    } cfg_t;

    cfg_t c_d, c_q;
    logic tail_ok;

    always_comb begin
        c_d     = c_q;
        tail_ok = (cfg_wdata[ALIGN_B-1:0] == '0);
        start   = cfg_wr && (cfg_sel == SEL_TAIL) && tail_ok && c_q.en && idle;
        abort   = cfg_wr && (cfg_sel == SEL_CTRL) && !cfg_wdata[0];
        if (cfg_wr) begin
            case (cfg_sel)
                SEL_CTRL: begin
                    c_d.en  = cfg_wdata[0];
                    c_d.vbl = cfg_wdata[1];
                end
                SEL_HEAD: c_d.head = {cfg_wdata[AW-1:3], 3'b000};
                SEL_TAIL: if (start) c_d.tail = cfg_wdata[AW-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign vbl_first = c_q.vbl;
    assign head      = c_q.head;
    assign tail      = c_q.tail;

endmodule

// File: rtl/cmdq_engine.sv
module cmdq_engine
    import cmdq_pkg::*;
#(
    parameter int AW         = 32,
    parameter int CYC_PER_US = 100,
    parameter int WAIT_W     = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_sel,
    input  logic [31:0]   cfg_wdata,
    input  logic          vblank,
    output logic          busy,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [63:0]   mem_rdata,
    output logic          rw_valid,
    input  logic          rw_ready,
    output logic [19:0]   rw_addr,
    output logic [31:0]   rw_data,
    output logic [3:0]    rw_be
);

    localparam logic [AW-1:0] STEP = AW'(8);

    typedef struct packed {
        state_t           st;
        logic [AW-1:0]    ptr;
        logic [63:0]      qw;
        logic [CNT_W-1:0] rem;
        logic [OFF_W-1:0] off;
        logic [3:0]       be;
    } eng_t;

    eng_t e_d, e_q;

    logic          start, abort, vbl_first;
    logic [AW-1:0] head, tail;
    kind_t         kind;
    logic          dec_vbl;
    logic [OFF_W-1:0]  dec_off;
    logic [3:0]        dec_be;
    logic [CNT_W-1:0]  dec_lo;
    logic [WAIT_W-1:0] dec_cnt;
    logic          tmr_load, vbl_rise, tmr_active;

    cmdq_cfg #(.AW(AW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .idle      (e_q.st == S_IDLE),
        .start     (start),
        .abort     (abort),
        .vbl_first (vbl_first),
        .head      (head),
        .tail      (tail)
    );

    cmdq_decode #(.WAIT_W(WAIT_W)) u_dec (
        .qword    (e_q.qw),
        .kind     (kind),
        .wait_vbl (dec_vbl),
        .offset   (dec_off),
        .be       (dec_be),
        .lo_word  (dec_lo),
        .wait_cnt (dec_cnt)
    );

    cmdq_timer #(.CYC_PER_US(CYC_PER_US), .WAIT_W(WAIT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .vblank   (vblank),
        .clear    (abort),
        .load     (tmr_load),
        .load_vbl (dec_vbl),
        .count    (dec_cnt),
        .vbl_rise (vbl_rise),
        .active   (tmr_active)
    );

    always_comb begin
        e_d      = e_q;
        mem_req  = 1'b0;
        rw_valid = 1'b0;
        tmr_load = 1'b0;
        case (e_q.st)
            S_IDLE: begin
                if (start) begin
                    e_d.ptr = head;
                    e_d.rem = '0;
                    e_d.st  = vbl_first ? S_VSYNC : S_REQ;
                end
            end
            S_VSYNC: begin
                if (vbl_rise) e_d.st = S_REQ;
            end
            S_REQ: begin
                if (e_q.ptr == tail) begin
                    e_d.st = S_IDLE;
                end else begin
                    mem_req = 1'b1;
                    e_d.st  = S_RESP;
                end
            end
            S_RESP: begin
                if (mem_rvalid) begin
                    e_d.qw  = mem_rdata;
                    e_d.ptr = e_q.ptr + STEP;
                    e_d.st  = (e_q.rem != '0) ? S_DLO : S_DEC;
                end
            end
            S_DEC: begin
                e_d.st = S_REQ;
                case (kind)
                    K_WRITE: begin
                        e_d.off = dec_off;
                        e_d.be  = dec_be;
                        e_d.st  = S_WR;
                    end
                    K_INDEXED: begin
                        e_d.off = dec_off;
                        e_d.be  = dec_be;
                        e_d.rem = dec_lo;
                    end
                    K_WAIT: begin
                        if (dec_cnt != '0) begin
                            tmr_load = 1'b1;
                            e_d.st   = S_WAIT;
                        end
                    end
                    default: ;
                endcase
            end
            S_WR: begin
                rw_valid = 1'b1;
                if (rw_ready) e_d.st = S_REQ;
            end
            S_DLO: begin
                rw_valid = 1'b1;
                if (rw_ready) begin
                    e_d.rem = e_q.rem - CNT_W'(1);
                    e_d.st  = (e_q.rem == CNT_W'(1)) ? S_REQ : S_DHI;
                end
            end
            S_DHI: begin
                rw_valid = 1'b1;
                if (rw_ready) begin
                    e_d.rem = e_q.rem - CNT_W'(1);
                    e_d.st  = S_REQ;
                end
            end
            S_WAIT: begin
                if (!tmr_active) e_d.st = S_REQ;
            end
            default: e_d.st = S_IDLE;
        endcase
        if (abort) begin
            e_d.st  = S_IDLE;
            e_d.rem = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q    <= '0;
            e_q.st <= S_IDLE;
        end else begin
            e_q <= e_d;
        end
    end

    assign busy     = (e_q.st != S_IDLE);
    assign mem_addr = e_q.ptr;
    assign rw_addr  = e_q.off;
    assign rw_be    = e_q.be;
    assign rw_data  = (e_q.st == S_DHI) ? e_q.qw[63:32] : e_q.qw[31:0];

endmodule

// File: rtl/cmdq_engine_chk.sv
module cmdq_engine_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_wr,
    input logic [1:0]    cfg_sel,
    input logic [31:0]   cfg_wdata,
    input logic          busy,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic          rw_valid,
    input logic          rw_ready,
    input logic [19:0]   rw_addr,
    input logic [31:0]   rw_data,
    input logic [3:0]    rw_be
);

    logic stop_wr;
    assign stop_wr = cfg_wr && (cfg_sel == 2'd0) && !cfg_wdata[0];

    // R3: a request never follows a request directly (one outstanding)
    a_r3_single_request: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R3: fetch addresses are qword aligned
    a_r3_qword_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[2:0] == 3'b000));

    // R6: enables are never all clear on a write
    a_r6_be_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        rw_valid |-> (rw_be != 4'h0));

    // R11: stop request empties the engine next cycle
    a_r11_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_wr |=> (!busy && !rw_valid && !mem_req));

    // R12: stalled write holds its contents
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rw_valid && !rw_ready && !stop_wr) |=>
            (rw_valid && $stable(rw_addr) && $stable(rw_data) && $stable(rw_be)));

    // R13: an idle engine issues nothing
    a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !rw_valid));

endmodule

bind cmdq_engine cmdq_engine_chk #(.AW(AW)) u_chk (.*);

// File: tb/cmdq_engine_test.sv
module cmdq_engine_test;

    localparam int AW  = 32;
    localparam int CYC = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [1:0]    cfg_sel = 2'd0;
    logic [31:0]   cfg_wdata = '0;
    logic          vblank = 1'b0;
    logic          busy, mem_req, rw_valid;
    logic [AW-1:0] mem_addr;
    logic          mem_rvalid = 1'b0;
    logic [63:0]   mem_rdata = '0;
    logic          rw_ready = 1'b1;
    logic [19:0]   rw_addr;
    logic [31:0]   rw_data;
    logic [3:0]    rw_be;

    cmdq_engine #(.AW(AW), .CYC_PER_US(CYC), .WAIT_W(16)) uut (.*);

    always #5 clk = ~clk;

    int total = 0;
    int bad   = 0;

    logic [63:0] mem [64];
    logic        slow = 1'b0;
    logic        stall = 1'b0;
    logic        clr = 1'b0;
    logic [31:0] exp_head = '0;
    logic        pend = 1'b0;
    logic [1:0]  dly = '0;
    logic [5:0]  paddr = '0;
    int          cyc = 0;
    int          nlog = 0;
    int          nreq = 0;
    int          badaddr = 0;
    logic [31:0] exp_addr = '0;
    logic [19:0] l_addr [32];
    logic [31:0] l_data [32];
    logic [3:0]  l_be   [32];
    int          l_t    [32];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        rw_ready <= stall ? (cyc % 4 == 3) : 1'b1;
        mem_rvalid <= 1'b0;
        if (mem_req) begin
            pend  <= 1'b1;
            dly   <= slow ? 2'd2 : 2'd0;
            paddr <= mem_addr[8:3];
        end else if (pend) begin
            if (dly == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[paddr];
                pend       <= 1'b0;
            end else begin
                dly <= dly - 2'd1;
            end
        end
        if (clr) begin
            nlog <= 0; nreq <= 0; badaddr <= 0; exp_addr <= exp_head;
        end else begin
            if (rw_valid && rw_ready && nlog < 32) begin
                l_addr[nlog] <= rw_addr; l_data[nlog] <= rw_data;
                l_be[nlog] <= rw_be; l_t[nlog] <= cyc;
                nlog <= nlog + 1;
            end
            if (mem_req) begin
                nreq <= nreq + 1;
                if (mem_addr != exp_addr) badaddr <= badaddr + 1;
                exp_addr <= exp_addr + 32'd8;
            end
        end
    end

    function automatic logic [63:0] hdr(input logic [7:0] op, input logic [3:0] be,
                                        input logic [19:0] off, input logic [31:0] lo);
        return {op, be, off, lo};
    endfunction

    task automatic check(input logic ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) mem[i] = '0;
    endtask

    task automatic arm(input logic [31:0] head, input logic [31:0] tail, input logic vf);
        @(negedge clk);
        exp_head = head; clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        cfg(2'd0, vf ? 32'd3 : 32'd1);
        cfg(2'd1, head);
        cfg(2'd2, tail);
    endtask

    task automatic wait_idle(input int limit);
        for (int i = 0; i < limit && busy; i++) @(negedge clk);
        check(!busy, "R13 busy clears at end", busy, 0);
    endtask

    task automatic pulse_vbl();
        @(negedge clk); vblank = 1'b1;
        repeat (2) @(negedge clk);
        vblank = 1'b0;
    endtask

    task automatic chk_wr(input int i, input logic [19:0] a, input logic [31:0] d,
                          input logic [3:0] b, input string tag);
        check(l_addr[i] == a, tag, l_addr[i], a);
        check(l_data[i] == d, tag, l_data[i], d);
        check(l_be[i] == b, tag, l_be[i], b);
    endtask

    initial begin
        #1_500_000;
        bad++; total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clear_mem();
        repeat (3) @(negedge clk);
        check(!busy && !mem_req && !rw_valid, "R1 reset quiet",
              {busy, mem_req, rw_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy, "R1 idle after reset", busy, 0);

        // R4 R7 R6: single writes among skipped opcodes
        mem[0] = hdr(8'h01, 4'hF, 20'h00010, 32'h11111111);
        mem[1] = hdr(8'h00, 4'h0, 20'h0, 32'h0);
        mem[2] = hdr(8'h03, 4'hF, 20'h5, 32'h9);
        mem[3] = hdr(8'h05, 4'hF, 20'h7, 32'h1);
        mem[4] = hdr(8'h07, 4'h0, 20'h0, 32'h0);
        mem[5] = hdr(8'h0A, 4'hF, 20'h8, 32'h2);
        mem[6] = hdr(8'hFF, 4'hF, 20'hFFFFF, 32'h3);
        mem[7] = hdr(8'h01, 4'h3, 20'hFFFFF, 32'h22222222);
        mem[8] = hdr(8'h01, 4'h0, 20'h00ABC, 32'h33333333);
        arm(32'd0, 32'd128, 1'b0);
        check(busy, "R13 busy after start", busy, 1);
        wait_idle(2000);
        check(nlog == 3, "R7 only write opcodes write", nlog, 3);
        chk_wr(0, 20'h00010, 32'h11111111, 4'hF, "R4 single write 0");
        chk_wr(1, 20'hFFFFF, 32'h22222222, 4'h3, "R4 single write 1");
        chk_wr(2, 20'h00ABC, 32'h33333333, 4'hF, "R6 zero enables widen");
        check(nreq == 16, "R3 fetch count to end", nreq, 16);
        check(badaddr == 0, "R3 fetch order", badaddr, 0);

        // R5 R6 R12: indexed sweep
        for (int c = 0; c <= 5; c++) begin
            logic [3:0] bf;
            logic [3:0] be_exp;
            int q;
            clear_mem();
            bf = 4'(c & 3);
            be_exp = (bf == 0) ? 4'hF : bf;
            mem[0] = hdr(8'h09, bf, 20'h00100 + 20'(c), 32'(c));
            for (int i = 0; i < c; i++) begin
                q = 1 + i / 2;
                if (i % 2 == 0) mem[q][31:0] = 32'hD000 + 32'(c * 16 + i);
                else mem[q][63:32] = 32'hD000 + 32'(c * 16 + i);
            end
            q = 1 + (c + 1) / 2;
            if (c % 2 == 1) mem[q - 1][63:32] = 32'hBAD0BAD0;
            mem[q] = hdr(8'h01, 4'h0, 20'h0005A, 32'h0000EEEE);
            slow = (c % 2 == 1);
            stall = (c % 2 == 1);
            arm(32'd0, 32'd64, 1'b0);
            wait_idle(4000);
            check(nlog == c + 1, "R5 indexed write count", nlog, c + 1);
            for (int i = 0; i < c; i++)
                chk_wr(i, 20'h00100 + 20'(c), 32'hD000 + 32'(c * 16 + i), be_exp,
                       "R5 indexed data order");
            chk_wr(c, 20'h0005A, 32'h0000EEEE, 4'hF, "R5 resume after pad");
            check(badaddr == 0, "R3 fetch order indexed", badaddr, 0);
        end
        slow = 1'b0; stall = 1'b0;

        // R8: microsecond wait, program placed at nonzero head
        clear_mem();
        mem[8]  = hdr(8'h01, 4'hF, 20'h00020, 32'hA);
        mem[9]  = hdr(8'h02, 4'h0, 20'h00003, 32'h0);
        mem[10] = hdr(8'h01, 4'hF, 20'h00021, 32'hB);
        arm(32'd64, 32'd128, 1'b0);
        wait_idle(2000);
        check(nlog == 2, "R8 writes around wait", nlog, 2);
        check(l_t[1] - l_t[0] >= 3 * CYC && l_t[1] - l_t[0] <= 3 * CYC + 16,
              "R8 wait length", l_t[1] - l_t[0], 3 * CYC);
        check(nreq == 8 && badaddr == 0, "R3 nonzero head", nreq, 8);

        // R9: vblank-count wait
        clear_mem();
        mem[0] = hdr(8'h01, 4'hF, 20'h00030, 32'h1);
        mem[1] = hdr(8'h04, 4'h0, 20'h00002, 32'h0);
        mem[2] = hdr(8'h04, 4'h0, 20'h00000, 32'h0);
        mem[3] = hdr(8'h01, 4'hF, 20'h00031, 32'h2);
        arm(32'd0, 32'd64, 1'b0);
        repeat (40) @(negedge clk);
        check(nlog == 1 && busy, "R9 held before edges", nlog, 1);
        pulse_vbl();
        repeat (20) @(negedge clk);
        check(nlog == 1, "R9 held after one edge", nlog, 1);
        pulse_vbl();
        wait_idle(2000);
        check(nlog == 2, "R9 released after two edges", nlog, 2);

        // R10: start on vblank
        clear_mem();
        mem[0] = hdr(8'h01, 4'h1, 20'h00040, 32'h77);
        arm(32'd0, 32'd64, 1'b1);
        repeat (30) @(negedge clk);
        check(busy && nreq == 0, "R10 no fetch before edge", nreq, 0);
        pulse_vbl();
        wait_idle(2000);
        check(nlog == 1 && l_data[0] == 32'h77, "R10 runs after edge", nlog, 1);

        // R11: stop during a long wait
        clear_mem();
        mem[0] = hdr(8'h01, 4'hF, 20'h00050, 32'h5);
        mem[1] = hdr(8'h02, 4'h0, 20'd1000, 32'h0);
        mem[2] = hdr(8'h01, 4'hF, 20'h00051, 32'h6);
        arm(32'd0, 32'd64, 1'b0);
        repeat (100) @(negedge clk);
        check(busy && nlog == 1, "R11 waiting before stop", nlog, 1);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'd0;
        @(negedge clk);
        cfg_wr = 1'b0;
        check(!busy, "R11 idle after stop", busy, 0);
        repeat (50) @(negedge clk);
        check(nlog == 1 && !busy, "R11 nothing after stop", nlog, 1);

        // R2: ignored end-address writes
        @(negedge clk); exp_head = 0; clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        cfg(2'd0, 32'd1);
        cfg(2'd1, 32'd0);
        cfg(2'd2, 32'h48);
        repeat (5) @(negedge clk);
        check(!busy && nreq == 0, "R2 unaligned end ignored", busy, 0);
        cfg(2'd0, 32'd0);
        cfg(2'd2, 32'd64);
        repeat (5) @(negedge clk);
        check(!busy && nreq == 0 && nlog == 0, "R2 disabled start ignored", busy, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule